// File: doc/BRIEF.md
# Register and Immediate ALU Instruction Decoder

This block turns one 32-bit RISC-V instruction word into the control and operand-index signals that a single-cycle datapath needs for integer ALU work. It has no clock and no state: every output is a function of the instruction word alone. It splits out the register indices and function fields and sign-extends the 12-bit immediate. It then decides whether the word is one of twelve supported ALU instructions: eight that take two registers and four that take a register and an immediate.

Downstream logic uses the 4-bit operation code to steer the ALU. It uses the operand-select output to choose the immediate over the second register read port. It gates the register-file write port with the write enable. Any word outside the supported set raises the illegal flag and suppresses the write, so an unsupported instruction never changes architectural state.

Top module: `rv_alu_decoder`

## Requirements
- R1: The outputs take these bits of the word: `rd_idx` from [11:7], `funct3` from [14:12], `rs1_idx` from [19:15], `rs2_idx` from [24:20], `funct7` from [31:25] and `opcode` from [6:0]. This holds whatever the word's legality.
- R2: `imm` is bits [31:20] sign-extended from bit 31 to 32 bits. For example, 0xFFF00093 yields 0xFFFFFFFF and an immediate field of 0x800 yields 0xFFFFF800.
- R3: For opcode 0110011 with funct7 0000000, the operation code is selected by funct3. 000 gives ADD=0, 001 gives SLL=5, 100 gives XOR=4, 101 gives SRL=6, 110 gives OR=3 and 111 gives AND=2.
- R4: For opcode 0110011 with funct7 0100000, funct3 000 gives SUB=1 and funct3 101 gives SRA=7. Every other funct3 with that funct7 is illegal, and so is any funct7 other than 0000000 or 0100000.
- R5: For opcode 0010011, funct3 000 gives ADD=0, 100 gives XOR=4, 110 gives OR=3 and 111 gives AND=2, whatever bits [31:25] hold. Funct3 001, 010, 011 and 101 are illegal.
- R6: For opcode 0110011, funct3 010 and 011 are illegal for every funct7.
- R7: Every opcode other than 0110011 and 0010011 is illegal.
- R8: `reg_we` is 1 exactly when the word is legal and `rd_idx` is not zero.
- R9: `use_imm` is 1 exactly for a legal word with opcode 0010011.
- R10: Exactly one of `is_rtype`, `is_itype` and `illegal` is 1. `is_rtype` marks a legal 0110011 word and `is_itype` marks a legal 0010011 word.
- R11: When `illegal` is 1, `alu_op` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to decode |
| opcode | output | 7 | Major opcode field |
| rd_idx | output | 5 | Destination register index |
| rs1_idx | output | 5 | First source register index |
| rs2_idx | output | 5 | Second source register index |
| funct3 | output | 3 | Minor function field |
| funct7 | output | 7 | Upper function field |
| imm | output | 32 | Sign-extended 12-bit immediate |
| is_rtype | output | 1 | Legal register-register ALU instruction |
| is_itype | output | 1 | Legal register-immediate ALU instruction |
| alu_op | output | 4 | ALU operation code |
| reg_we | output | 1 | Register-file write enable |
| use_imm | output | 1 | Second ALU operand comes from the immediate |
| illegal | output | 1 | Word is outside the supported set |

## Verification
The bench targets the funct7 qualifier, which is where a decoder can go wrong in two ways. It can ignore the qualifier and turn SUB into ADD, or it can accept funct7 0100000 with funct3 values such as 111 and decode AND where illegal is due. The bench sends immediate words whose upper bits look like the alternate funct7, to catch a decoder that wrongly qualifies immediate forms and rejects ANDI with a negative immediate. The illegal funct3 values of both forms, foreign opcodes and rd of zero probe write suppression; a wrong gate there would corrupt a register or write x0. Immediates with bit 31 set expose a zero-extending immediate path.

// File: rtl/rv_alu_decoder_pkg.sv
package rv_alu_decoder_pkg;

  localparam int unsigned ILEN     = 32;
  localparam int unsigned OPC_W    = 7;
  localparam int unsigned REG_AW   = 5;
  localparam int unsigned F3_W     = 3;
  localparam int unsigned F7_W     = 7;
  localparam int unsigned IMM_W    = 12;
  localparam int unsigned ALUOP_W  = 4;

  localparam logic [OPC_W-1:0] OPC_REG = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMM = 7'b0010011;

  localparam logic [F7_W-1:0]  F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0]  F7_ALT  = 7'b0100000;

  typedef enum logic [ALUOP_W-1:0] {
    ALU_ADD = 4'd0,
    ALU_SUB = 4'd1,
    ALU_AND = 4'd2,
    ALU_OR  = 4'd3,
    ALU_XOR = 4'd4,
    ALU_SLL = 4'd5,
    ALU_SRL = 4'd6,
    ALU_SRA = 4'd7
  } alu_op_e;

  typedef struct packed {
    logic [F7_W-1:0]   f7;
    logic [REG_AW-1:0] rs2;
    logic [REG_AW-1:0] rs1;
    logic [F3_W-1:0]   f3;
    logic [REG_AW-1:0] rd;
    logic [OPC_W-1:0]  opc;
  } instr_fields_t;

endpackage

// File: rtl/rv_dec_fields.sv
module rv_dec_fields
  import rv_alu_decoder_pkg::*;
(
  input  logic [ILEN-1:0]  word_i,
  output instr_fields_t    fld_o,
  output logic [IMM_W-1:0] imm_raw_o
);

  // The packed struct mirrors the instruction layout bit for bit.
  assign fld_o     = instr_fields_t'(word_i);
  assign imm_raw_o = word_i[ILEN-1 -: IMM_W];

endmodule

// File: rtl/rv_dec_imm_ext.sv
module rv_dec_imm_ext #(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  raw_i,
  output logic [OUT_W-1:0] ext_o
);

  localparam int unsigned PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W == 0) begin : g_no_pad
      assign ext_o = raw_i;
    end else begin : g_pad
      assign ext_o = {{PAD_W{raw_i[IN_W-1]}}, raw_i};
    end
  endgenerate

endmodule

// File: rtl/rv_dec_op_sel.sv
module rv_dec_op_sel
  import rv_alu_decoder_pkg::*;
(
  input  logic [OPC_W-1:0]   opc_i,
  input  logic [F3_W-1:0]    f3_i,
  input  logic [F7_W-1:0]    f7_i,
  output logic               reg_form_o,
  output logic               imm_form_o,
  output logic [ALUOP_W-1:0] op_o
);

  logic    reg_ok;
  logic    imm_ok;
  alu_op_e reg_op;
  alu_op_e imm_op;

  // Register-register form: funct7 qualifies add/sub and the right shifts.
  always_comb begin
    reg_ok = 1'b0;
    reg_op = ALU_ADD;
    if (f7_i == F7_BASE) begin
      reg_ok = 1'b1;
      unique case (f3_i)
        3'b000:  reg_op = ALU_ADD;
        3'b001:  reg_op = ALU_SLL;
        3'b100:  reg_op = ALU_XOR;
        3'b101:  reg_op = ALU_SRL;
        3'b110:  reg_op = ALU_OR;
        3'b111:  reg_op = ALU_AND;
        default: reg_ok = 1'b0;
      endcase
    end else if (f7_i == F7_ALT) begin
      unique case (f3_i)
        3'b000: begin reg_ok = 1'b1; reg_op = ALU_SUB; end
        3'b101: begin reg_ok = 1'b1; reg_op = ALU_SRA; end
        default: reg_ok = 1'b0;
      endcase
    end
  end

  // Register-immediate form: upper bits are immediate, never a qualifier.
  always_comb begin
    imm_ok = 1'b1;
    imm_op = ALU_ADD;
    unique case (f3_i)
      3'b000:  imm_op = ALU_ADD;
      3'b100:  imm_op = ALU_XOR;
      3'b110:  imm_op = ALU_OR;
      3'b111:  imm_op = ALU_AND;
      default: imm_ok = 1'b0;
    endcase
  end

  always_comb begin
    reg_form_o = (opc_i == OPC_REG) && reg_ok;
    imm_form_o = (opc_i == OPC_IMM) && imm_ok;
    if (reg_form_o)      op_o = reg_op;
    else if (imm_form_o) op_o = imm_op;
    else                 op_o = ALU_ADD;
  end

endmodule

// File: rtl/rv_alu_decoder.sv
module rv_alu_decoder
  import rv_alu_decoder_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [ILEN-1:0]    instr,
  output logic [OPC_W-1:0]   opcode,
  output logic [REG_AW-1:0]  rd_idx,
  output logic [REG_AW-1:0]  rs1_idx,
  output logic [REG_AW-1:0]  rs2_idx,
  output logic [F3_W-1:0]    funct3,
  output logic [F7_W-1:0]    funct7,
  output logic [XLEN-1:0]    imm,
  output logic               is_rtype,
  output logic               is_itype,
  output logic [ALUOP_W-1:0] alu_op,
  output logic               reg_we,
  output logic               use_imm,
  output logic               illegal
);

  instr_fields_t    fld;
  logic [IMM_W-1:0] imm_raw;
  logic             reg_form;
  logic             imm_form;
  logic             legal;

  rv_dec_fields u_fields (
    .word_i    (instr),
    .fld_o     (fld),
    .imm_raw_o (imm_raw)
  );

  rv_dec_imm_ext #(
    .IN_W  (IMM_W),
    .OUT_W (XLEN)
  ) u_imm (
    .raw_i (imm_raw),
    .ext_o (imm)
  );

  rv_dec_op_sel u_op (
    .opc_i      (fld.opc),
    .f3_i       (fld.f3),
    .f7_i       (fld.f7),
    .reg_form_o (reg_form),
    .imm_form_o (imm_form),
    .op_o       (alu_op)
  );

  assign opcode   = fld.opc;
  assign rd_idx   = fld.rd;
  assign rs1_idx  = fld.rs1;
  assign rs2_idx  = fld.rs2;
  assign funct3   = fld.f3;
  assign funct7   = fld.f7;

  assign legal    = reg_form | imm_form;
  assign is_rtype = reg_form;
  assign is_itype = imm_form;
  assign use_imm  = imm_form;
  assign illegal  = ~legal;
  assign reg_we   = legal & (fld.rd != '0);

endmodule

// File: rtl/rv_alu_decoder_chk.sv
module rv_alu_decoder_chk
  import rv_alu_decoder_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic [ILEN-1:0]    instr,
  input logic [REG_AW-1:0]  rd_idx,
  input logic [XLEN-1:0]    imm,
  input logic               is_rtype,
  input logic               is_itype,
  input logic [ALUOP_W-1:0] alu_op,
  input logic               reg_we,
  input logic               use_imm,
  input logic               illegal
);

  always_comb begin
    // R8
    we_gate_chk: assert (!reg_we || (!illegal && rd_idx != '0));
    // R10
    one_class_chk: assert ($countones({is_rtype, is_itype, illegal}) == 1);
    // R9
    imm_sel_chk: assert (use_imm == is_itype);
    // R11
    idle_op_chk: assert (!illegal || alu_op == '0);
    // R2
    sign_fill_chk: assert (imm[XLEN-1:IMM_W] == {(XLEN-IMM_W){instr[ILEN-1]}});
    // R7
    opc_gate_chk: assert (illegal || instr[6:0] == OPC_REG || instr[6:0] == OPC_IMM);
  end

endmodule

bind rv_alu_decoder rv_alu_decoder_chk #(.XLEN(XLEN)) u_chk (
  .instr    (instr),
  .rd_idx   (rd_idx),
  .imm      (imm),
  .is_rtype (is_rtype),
  .is_itype (is_itype),
  .alu_op   (alu_op),
  .reg_we   (reg_we),
  .use_imm  (use_imm),
  .illegal  (illegal)
);

// File: tb/rv_alu_decoder_test.sv
`timescale 1ns/1ps
module rv_alu_decoder_test;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [6:0]  opcode;
  logic [4:0]  rd_idx, rs1_idx, rs2_idx;
  logic [2:0]  funct3;
  logic [6:0]  funct7;
  logic [31:0] imm;
  logic        is_rtype, is_itype, reg_we, use_imm, illegal;
  logic [3:0]  alu_op;

  int n_vec;
  int n_bad;
  bit done;
  bit vld;

  // kind: 0 illegal, 1 register form, 2 immediate form
  typedef struct {
    logic [31:0] w;
    int          kind;
    logic [3:0]  op;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  rv_alu_decoder uut (
    .instr    (instr),
    .opcode   (opcode),
    .rd_idx   (rd_idx),
    .rs1_idx  (rs1_idx),
    .rs2_idx  (rs2_idx),
    .funct3   (funct3),
    .funct7   (funct7),
    .imm      (imm),
    .is_rtype (is_rtype),
    .is_itype (is_itype),
    .alu_op   (alu_op),
    .reg_we   (reg_we),
    .use_imm  (use_imm),
    .illegal  (illegal)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] rw(input logic [6:0] f7, input logic [4:0] s2,
                                     input logic [4:0] s1, input logic [2:0] f3,
                                     input logic [4:0] d);
    return {f7, s2, s1, f3, d, 7'b0110011};
  endfunction

  function automatic logic [31:0] iw(input logic [11:0] im, input logic [4:0] s1,
                                     input logic [2:0] f3, input logic [4:0] d);
    return {im, s1, f3, d, 7'b0010011};
  endfunction

  task automatic apply(input logic [31:0] w, input int kind, input logic [3:0] op,
                       input string tag);
    exp_t e;
    e.w = w; e.kind = kind; e.op = op; e.tag = tag;
    @(posedge clk);
    exp_q.push_back(e);
    instr <= w;
    vld   <= 1'b1;
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp, inout bit bad);
    if (act !== exp) begin
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      bad = 1'b1;
    end
  endtask

  // Monitor: compares settled outputs away from the driving edge.
  always @(negedge clk) begin
    if (rst_n && vld && exp_q.size() > 0) begin
      exp_t e;
      bit   bad;
      logic legal;
      e     = exp_q.pop_front();
      bad   = 1'b0;
      legal = (e.kind != 0);
      cmp({e.tag, "/R1"}, "opcode", 32'(opcode), 32'(e.w[6:0]), bad);
      cmp({e.tag, "/R1"}, "rd", 32'(rd_idx), 32'(e.w[11:7]), bad);
      cmp({e.tag, "/R1"}, "funct3", 32'(funct3), 32'(e.w[14:12]), bad);
      cmp({e.tag, "/R1"}, "rs1", 32'(rs1_idx), 32'(e.w[19:15]), bad);
      cmp({e.tag, "/R1"}, "rs2", 32'(rs2_idx), 32'(e.w[24:20]), bad);
      cmp({e.tag, "/R1"}, "funct7", 32'(funct7), 32'(e.w[31:25]), bad);
      cmp({e.tag, "/R2"}, "imm", imm, {{20{e.w[31]}}, e.w[31:20]}, bad);
      cmp({e.tag, "/R10"}, "is_rtype", 32'(is_rtype), 32'(e.kind == 1), bad);
      cmp({e.tag, "/R10"}, "is_itype", 32'(is_itype), 32'(e.kind == 2), bad);
      cmp(e.tag, "illegal", 32'(illegal), 32'(!legal), bad);
      cmp({e.tag, "/R11"}, "alu_op", 32'(alu_op), 32'(legal ? e.op : 4'd0), bad);
      cmp({e.tag, "/R8"}, "reg_we", 32'(reg_we), 32'(legal && e.w[11:7] != 5'd0), bad);
      cmp({e.tag, "/R9"}, "use_imm", 32'(use_imm), 32'(e.kind == 2), bad);
      n_vec++;
      if (bad) n_bad++;
    end
  end

  initial begin
    rst_n = 1'b0;
    vld   = 1'b0;
    instr = 32'h0;
    n_vec = 0;
    n_bad = 0;
    done  = 1'b0;
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;

    apply(32'h0000_0000, 0, 4'd0, "R7 zero word");
    apply(32'h0050_0093, 2, 4'd0, "R5 addi x1,x0,5");
    apply(32'hFFF0_0093, 2, 4'd0, "R2 addi imm -1");
    apply(32'h0020_81B3, 1, 4'd0, "R3 add x3,x1,x2");
    apply(rw(7'b0100000, 5'd2, 5'd1, 3'b000, 5'd4), 1, 4'd1, "R4 sub");
    apply(rw(7'b0000000, 5'd7, 5'd6, 3'b001, 5'd5), 1, 4'd5, "R3 sll");
    apply(rw(7'b0000000, 5'd9, 5'd8, 3'b100, 5'd10), 1, 4'd4, "R3 xor");
    apply(rw(7'b0000000, 5'd3, 5'd2, 3'b101, 5'd11), 1, 4'd6, "R3 srl");
    apply(rw(7'b0100000, 5'd3, 5'd2, 3'b101, 5'd12), 1, 4'd7, "R4 sra");
    apply(rw(7'b0000000, 5'd31, 5'd30, 3'b110, 5'd29), 1, 4'd3, "R3 or");
    apply(rw(7'b0000000, 5'd1, 5'd2, 3'b111, 5'd31), 1, 4'd2, "R3 and");
    apply(rw(7'b0000000, 5'd1, 5'd2, 3'b010, 5'd3), 0, 4'd0, "R6 funct3 010");
    apply(rw(7'b0100000, 5'd1, 5'd2, 3'b011, 5'd3), 0, 4'd0, "R6 funct3 011");
    apply(rw(7'b0000001, 5'd1, 5'd2, 3'b000, 5'd3), 0, 4'd0, "R4 funct7 0000001");
    apply(rw(7'b0100000, 5'd1, 5'd2, 3'b111, 5'd3), 0, 4'd0, "R4 alt funct7 and");
    apply(rw(7'b0100000, 5'd1, 5'd2, 3'b001, 5'd3), 0, 4'd0, "R4 alt funct7 sll");
    apply(rw(7'b1111111, 5'd1, 5'd2, 3'b101, 5'd3), 0, 4'd0, "R4 funct7 1111111");
    apply(iw(12'h123, 5'd4, 3'b100, 5'd6), 2, 4'd4, "R5 xori");
    apply(iw(12'h400, 5'd4, 3'b110, 5'd7), 2, 4'd3, "R5 ori alt-looking top bits");
    apply(iw(12'h800, 5'd5, 3'b111, 5'd8), 2, 4'd2, "R2 andi imm 0x800");
    apply(iw(12'hFF0, 5'd5, 3'b111, 5'd9), 2, 4'd2, "R5 andi negative");
    apply(iw(12'h001, 5'd1, 3'b001, 5'd2), 0, 4'd0, "R5 imm funct3 001");
    apply(iw(12'h401, 5'd1, 3'b101, 5'd2), 0, 4'd0, "R5 imm funct3 101");
    apply(iw(12'h001, 5'd1, 3'b010, 5'd2), 0, 4'd0, "R5 imm funct3 010");
    apply(iw(12'h001, 5'd1, 3'b011, 5'd2), 0, 4'd0, "R5 imm funct3 011");
    apply(rw(7'b0000000, 5'd2, 5'd1, 3'b000, 5'd0), 1, 4'd0, "R8 add rd zero");
    apply(iw(12'h000, 5'd0, 3'b000, 5'd0), 2, 4'd0, "R8 addi nop");
    apply(32'h0000_10B7, 0, 4'd0, "R7 upper-imm opcode");
    apply(32'h0000_2083, 0, 4'd0, "R7 load opcode");
    apply(32'h0020_81B2, 0, 4'd0, "R7 opcode low bits 10");
    apply(32'h8020_81BB, 0, 4'd0, "R7 word-op opcode");

    @(posedge clk);
    vld <= 1'b0;
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule